// File: doc/BRIEF.md
# Card Bus Symbol Framer

This block passively watches a synchronous three-wire memory-card bus. The bus has a reset line, a clock line and a bidirectional data line. The block samples all three lines with a faster system clock and turns their edge activity into bus symbols: reset, interrupt, start, stop and data bit. It also gathers data bits into bytes.

Each symbol is reported as a one-cycle strobe that carries a symbol code. A completed byte is reported as a separate one-cycle strobe together with its value. A raw strobe marks each bit sample, so a processing-phase monitor can follow the data line clock by clock. A higher layer drives a mask input while the card is sending data or is busy processing. While the mask is high, start and stop detection is switched off.

Top module: `card_bus_framer`

## Requirements
- R1: While the synchronized reset line is high, no bit (code 5), start (code 3) or stop (code 4) symbol and no byte strobe is produced.
- R2: A falling edge of the reset line produces a reset symbol (code 1) if a full clock pulse, rise then fall, was seen while reset was high.
- R3: A falling edge of the reset line with no full clock pulse during the high period produces an interrupt symbol (code 2). A clock rise alone does not count as a pulse.
- R4: With reset low, a rising clock edge samples the data line and pulses `bit_stb` with that value in `bit_val`.
- R5: With reset low, a falling clock edge that follows an opening rise emits a bit symbol (code 5).
- R6: With the clock high and reset low, a falling data edge emits start (code 3) and a rising data edge emits stop (code 4).
- R7: While `cond_mask` is high, data-line edges during a high clock emit no start or stop and leave the bits already collected intact.
- R8: Eight bit symbols form a byte, assembled least-significant bit first. `byte_stb` pulses in the same cycle as the eighth bit symbol, with the byte in `byte_data`.
- R9: Reset, start and stop each discard any partially collected bits.
- R10: A falling clock edge with no opening rise emits no bit symbol and clears the bit count.
- R11: Each line passes through a two-flop synchronizer. Every strobe is one system clock wide and appears three system clocks after the line change that causes it. All strobes are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset of the block |
| line_rst | input | 1 | Bus reset line (asynchronous) |
| line_clk | input | 1 | Bus clock line (asynchronous) |
| line_io | input | 1 | Bus data line (asynchronous) |
| cond_mask | input | 1 | High during data-out or processing phases; disables start/stop |
| sym_stb | output | 1 | One-cycle symbol strobe |
| sym_code | output | 3 | Symbol code: 1 reset, 2 interrupt, 3 start, 4 stop, 5 bit |
| bit_stb | output | 1 | One-cycle strobe on each bit sample |
| bit_val | output | 1 | Sampled data value |
| byte_stb | output | 1 | One-cycle strobe for a completed byte |
| byte_data | output | BYTE_W | Assembled byte, first bit in bit 0 |

## Verification
The bench builds the block with its default values, a two-stage synchronizer and eight-bit bytes. With these values the three-cycle line-to-strobe latency can be checked at exact cycles. A byte table covers the all-zero, all-one and single-set-bit edge positions of the LSB-first packing. Directed sequences drive reset pulses with a full clock pulse, with a clock rise only and with no clock activity. They also drive masked data-line glitches inside an open bit period and orphan falling clock edges after a start condition.

// File: rtl/card_bus_framer.sv
module card_bus_framer #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_rst,
  input  logic              line_clk,
  input  logic              line_io,
  input  logic              cond_mask,
  output logic              sym_stb,
  output logic [2:0]        sym_code,
  output logic              bit_stb,
  output logic              bit_val,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_data
);
  localparam int CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);
  localparam logic [2:0] C_RESET = 3'd1, C_INTR = 3'd2, C_START = 3'd3,
                         C_STOP  = 3'd4, C_BIT  = 3'd5;

  logic [SYNC_STAGES-1:0] sy_r, sy_c, sy_d;
  logic p_r, p_c, p_d;
  logic clk_half, clk_full, open_q, smp;
  logic [BYTE_W-1:0] acc;
  logic [CW-1:0] cnt;

  wire s_r = sy_r[SYNC_STAGES-1];
  wire s_c = sy_c[SYNC_STAGES-1];
  wire s_d = sy_d[SYNC_STAGES-1];
  wire r_rise = s_r & ~p_r;
  wire r_fall = ~s_r & p_r;
  wire c_rise = s_c & ~p_c;
  wire c_fall = ~s_c & p_c;
  wire d_edge = s_d ^ p_d;
  wire cond_ok = s_c & p_c & ~cond_mask & d_edge;
  wire [BYTE_W-1:0] nxt = {smp, acc[BYTE_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy_r <= '0; sy_c <= '0; sy_d <= '0;
      p_r <= 1'b0; p_c <= 1'b0; p_d <= 1'b0;
    end else begin
      sy_r <= {sy_r[SYNC_STAGES-2:0], line_rst};
      sy_c <= {sy_c[SYNC_STAGES-2:0], line_clk};
      sy_d <= {sy_d[SYNC_STAGES-2:0], line_io};
      p_r <= s_r; p_c <= s_c; p_d <= s_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym_stb <= 1'b0; sym_code <= '0; bit_stb <= 1'b0; bit_val <= 1'b0;
      byte_stb <= 1'b0; byte_data <= '0;
      clk_half <= 1'b0; clk_full <= 1'b0; open_q <= 1'b0; smp <= 1'b0;
      acc <= '0; cnt <= '0;
    end else begin
      sym_stb <= 1'b0; bit_stb <= 1'b0; byte_stb <= 1'b0;
      if (r_rise) begin
        clk_half <= 1'b0; clk_full <= 1'b0; open_q <= 1'b0; cnt <= '0;
      end else if (r_fall) begin
        sym_stb  <= 1'b1;
        sym_code <= clk_full ? C_RESET : C_INTR;
        open_q   <= 1'b0; cnt <= '0;
      end else if (s_r) begin
        if (c_rise) clk_half <= 1'b1;
        if (c_fall && clk_half) clk_full <= 1'b1;
      end else if (c_rise) begin
        open_q <= 1'b1; smp <= s_d; bit_stb <= 1'b1; bit_val <= s_d;
      end else if (c_fall) begin
        open_q <= 1'b0;
        if (open_q) begin
          acc <= nxt; sym_stb <= 1'b1; sym_code <= C_BIT;
          if (cnt == LAST) begin
            byte_stb <= 1'b1; byte_data <= nxt; cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          cnt <= '0;
        end
      end else if (cond_ok) begin
        sym_stb  <= 1'b1;
        sym_code <= s_d ? C_STOP : C_START;
        open_q   <= 1'b0; cnt <= '0;
      end
    end
  end

  AST_RST_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(s_r && p_r) |-> !byte_stb && !(sym_stb && sym_code >= C_START)); // R1
  AST_RST_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && sym_code <= C_INTR) |-> $past(p_r && !s_r)); // R2
  AST_BIT_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && sym_code == C_BIT) |-> $past(open_q && c_fall)); // R5
  AST_MASK_COND: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cond_mask) |-> !(sym_stb && (sym_code == C_START || sym_code == C_STOP))); // R7
  AST_BYTE_WITH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> sym_stb && sym_code == C_BIT); // R8
endmodule

// File: tb/card_bus_framer_tb.sv
module card_bus_framer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic line_rst = 1'b0, line_clk = 1'b0, line_io = 1'b1, cond_mask = 1'b0;
  logic sym_stb, bit_stb, bit_val, byte_stb;
  logic [2:0] sym_code;
  logic [7:0] byte_data;

  always #4 clk = ~clk;

  card_bus_framer dut_i (.clk(clk), .rst_n(rst_n), .line_rst(line_rst),
    .line_clk(line_clk), .line_io(line_io), .cond_mask(cond_mask),
    .sym_stb(sym_stb), .sym_code(sym_code), .bit_stb(bit_stb), .bit_val(bit_val),
    .byte_stb(byte_stb), .byte_data(byte_data));

  int errors = 0, checks = 0;
  int n_code [8];
  int n_byte = 0, n_raw = 0, multi = 0;
  logic [7:0] last_byte;
  logic last_raw;
  logic [2:0] last_code;
  logic prev_any = 1'b0;

  always @(posedge clk) begin
    #2;
    if (sym_stb) begin n_code[sym_code]++; last_code = sym_code; end
    if (byte_stb) begin n_byte++; last_byte = byte_data; end
    if (bit_stb) begin n_raw++; last_raw = bit_val; end
    if ((sym_stb || bit_stb) && prev_any) multi++;
    prev_any = sym_stb || bit_stb;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic v);
    line_io = v; step(5); line_clk = 1'b1; step(5); line_clk = 1'b0; step(5);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int k = 0; k < 8; k++) send_bit(b[k]);
  endtask

  task automatic start_cond();
    line_io = 1'b1; step(5); line_clk = 1'b1; step(5); line_io = 1'b0; step(5);
    line_clk = 1'b0; step(5);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  localparam logic [7:0] VEC [6] = '{8'hA5, 8'h01, 8'h80, 8'hFF, 8'h00, 8'h3C};

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int b0, s0, r0, st0, sp0, c5;
    for (int i = 0; i < 8; i++) n_code[i] = 0;
    step(4); rst_n = 1'b1; step(6);
    chk(!sym_stb && !bit_stb && !byte_stb, "R11 reset state", {sym_stb, bit_stb, byte_stb}, 0);

    // R6/R11: exact latency of a stop condition
    line_io = 1'b1; step(5); line_clk = 1'b1; step(5);
    st0 = n_code[3];
    line_io = 1'b0; step(5);
    chk(n_code[3] == st0 + 1 && last_code == 3, "R6 start", last_code, 3);
    @(negedge clk) line_io = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(!sym_stb, "R11 latency before", sym_stb, 0);
    @(negedge clk);
    chk(sym_stb && sym_code == 3'd4, "R11 latency stop", {sym_stb, sym_code}, 4'hC);
    @(negedge clk);
    chk(!sym_stb, "R11 one cycle wide", sym_stb, 0);
    c5 = n_code[5];
    line_clk = 1'b0; step(5);
    chk(n_code[5] == c5, "R10 orphan fall no bit", n_code[5], c5);

    // table of bytes, each framed by a start condition
    foreach (VEC[i]) begin
      start_cond();
      b0 = n_byte; s0 = n_code[5]; r0 = n_raw;
      send_byte(VEC[i]);
      chk(n_byte == b0 + 1 && last_byte == VEC[i], "R8 byte", last_byte, VEC[i]);
      chk(n_code[5] == s0 + 8, "R5 bit symbols", n_code[5] - s0, 8);
      chk(n_raw == r0 + 8 && last_raw == VEC[i][7], "R4 raw bit", last_raw, VEC[i][7]);
    end

    // R2 and R1: full clock pulse with data glitches while reset high
    b0 = n_byte; s0 = n_code[5]; st0 = n_code[3]; sp0 = n_code[4];
    line_rst = 1'b1; step(5); line_clk = 1'b1; step(5);
    line_io = 1'b0; step(5); line_io = 1'b1; step(5); line_clk = 1'b0; step(5);
    chk(n_code[5] == s0 && n_code[3] == st0 && n_code[4] == sp0 && n_byte == b0,
        "R1 silent in reset", n_code[5] + n_code[3] + n_code[4], s0 + st0 + sp0);
    line_rst = 1'b0; step(5);
    chk(last_code == 3'd1, "R2 reset symbol", last_code, 1);

    // R3: no clock activity
    line_rst = 1'b1; step(5); line_rst = 1'b0; step(5);
    chk(last_code == 3'd2, "R3 interrupt plain", last_code, 2);
    // R3: clock rise only, then R10 orphan fall after release
    line_rst = 1'b1; step(5); line_clk = 1'b1; step(5); line_rst = 1'b0; step(5);
    chk(last_code == 3'd2, "R3 interrupt rise only", last_code, 2);
    s0 = n_code[5];
    line_clk = 1'b0; step(5);
    chk(n_code[5] == s0, "R10 orphan after reset", n_code[5], s0);

    // R9: partial bits dropped by a reset pulse
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    line_rst = 1'b1; step(5); line_rst = 1'b0; step(5);
    b0 = n_byte;
    send_byte(8'h5A);
    chk(n_byte == b0 + 1 && last_byte == 8'h5A, "R9 reset clears", last_byte, 8'h5A);

    // R9: partial bits dropped by a start condition
    send_bit(1'b1); send_bit(1'b1);
    start_cond();
    b0 = n_byte;
    send_byte(8'hC3);
    chk(n_byte == b0 + 1 && last_byte == 8'hC3, "R9 start clears", last_byte, 8'hC3);

    // R7: masked glitches inside an open bit period keep collected bits
    start_cond();
    cond_mask = 1'b1;
    st0 = n_code[3]; sp0 = n_code[4]; b0 = n_byte;
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    line_io = 1'b1; step(5); line_clk = 1'b1; step(5);
    line_io = 1'b0; step(5); line_io = 1'b1; step(5);
    line_clk = 1'b0; step(5);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    chk(n_code[3] == st0 && n_code[4] == sp0, "R7 no start/stop", n_code[3] + n_code[4], st0 + sp0);
    chk(n_byte == b0 + 1 && last_byte == 8'h6A, "R7 bits kept", last_byte, 8'h6A);
    cond_mask = 1'b0;

    chk(multi == 0, "R11 strobes single cycle", multi, 0);
    finish_run();
  end
endmodule